// File: doc/BRIEF.md
# Interrupt Pending Flags and Request Gating

This block keeps one pending flag per interrupt source and decides which sources put a request in front of the CPU sequencer. The source condition detectors give it one condition line per source. The block looks at these lines only on cycles where the machine-cycle strobe is high. A flag becomes pending whenever its condition is seen, whether or not the source is enabled. Software can read the flag vector at any time.

Each class of source clears its flag in a different way:
- Plain sources clear only when software writes a clear.
- The two timer sources also clear when the CPU acknowledges their vector.
- The two external-pin sources clear on acknowledge only in edge mode. In level mode their flag simply mirrors the last sampled pin condition.

A request reaches the sequencer only when the flag is pending and the source's own enable bit is set. The global enable bit must also be set, except for the power-fail source, which depends only on its own enable bit.

The block is meant to sit between the condition detectors and the priority resolver. The enable register is written through a simple write strobe. Flags are cleared through a mask write.

Top module: `irq_flag_gate`

## Requirements
- R1: With `mc_tick` high, a high `cond_in[i]` makes `flags_o[i]` equal to 1 from the next cycle on, whatever the enable register holds.
- R2: `cond_in` has no effect on any flag in a cycle where `mc_tick` is low.
- R3: A cycle with `clr_we` high clears, from the next cycle, every latched flag whose `clr_mask` bit is 1. Flags whose mask bit is 0 keep their value.
- R4: When a flag's set and its software clear (or its acknowledge clear) happen in the same cycle, the flag ends up set.
- R5: For the external sources at indices 0 and 2 with `lvl_mode` bit 0 (edge mode), an acknowledge (`ack_vld`=1) whose `ack_idx` equals the source's index clears its flag.
- R6: For the external sources at indices 0 and 2 with `lvl_mode` bit 1 (level mode), the flag takes the sampled `cond_in` value on every `mc_tick` and ignores software clears and acknowledges. For all other sources `lvl_mode` is ignored.
- R7: The timer sources at indices 1 and 3 clear their flag on an acknowledge of their index in every case. An acknowledge of indices 4, 5 or 6 leaves the flags unchanged.
- R8: While `ack_vld` is low, `ack_idx` clears no flag.
- R9: `req_o[i]` is 1 only when `flags_o[i]` is 1 and enable bit i is 1.
- R10: Enable bit 7 is the global enable. When it is 0, every request is 0 except that of the power-fail source at index 6.
- R11: The request of the power-fail source at index 6 equals its flag ANDed with enable bit 6, whatever the global enable bit holds.
- R12: A cycle with `en_we` high loads `en_wdata` into the enable register. The result is seen at `req_o` from the next cycle.
- R13: Reset clears all flags, all enable bits and the global enable bit, so `flags_o` and `req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe; conditions are sampled when high |
| cond_in | input | 7 | Per-source condition lines, active high |
| lvl_mode | input | 7 | Per-source mode; 1 selects level mode (used by indices 0 and 2 only) |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data; bit 7 is the global enable |
| clr_we | input | 1 | Software flag-clear strobe |
| clr_mask | input | 7 | Flags to clear, one bit per source |
| ack_vld | input | 1 | Vector acknowledge, one cycle wide |
| ack_idx | input | 3 | Index of the source being vectored to |
| flags_o | output | 7 | Pending flag vector |
| req_o | output | 7 | Gated request vector |

## Verification
Every flag is visible directly at `flags_o`, so a wrongly kept or wrongly lost flag shows up in the cycle right after the edge that should have set or cleared it. A wrong enable or global-enable state stays hidden until some flag is pending. For that reason the bench fills the flag vector before it writes each enable pattern, so that a bad enable bit shows at `req_o` one cycle after the write. A level-mode mix-up is caught by checking that acknowledges and clears leave a level-mode flag unchanged, and that the next tick overwrites it with the pin condition.

// File: rtl/irq_gate_pkg.sv
`timescale 1ns/1ps
package irq_gate_pkg;

  typedef enum logic [1:0] {
    SRC_PLAIN = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EXT   = 2'd2
  } src_kind_e;

  // classify a source index against the configured role indices
  function automatic src_kind_e src_kind(input int idx, input int ext_a,
                                         input int ext_b, input int tmr_a,
                                         input int tmr_b);
    if (idx == ext_a || idx == ext_b) return SRC_EXT;
    if (idx == tmr_a || idx == tmr_b) return SRC_TIMER;
    return SRC_PLAIN;
  endfunction

  // latched flag update: a set always beats any clear
  function automatic logic latch_next(input logic cur, input logic set_i,
                                      input logic clr_i);
    return set_i | (cur & ~clr_i);
  endfunction

  // request gating: power-fail bypasses the global enable
  function automatic logic gate_req(input logic flag, input logic en,
                                    input logic gie, input logic bypass);
    return flag & en & (gie | bypass);
  endfunction

endpackage

// File: rtl/irq_flag_cell.sv
`timescale 1ns/1ps
module irq_flag_cell
  import irq_gate_pkg::*;
#(
  parameter src_kind_e KIND = SRC_PLAIN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_tick,
  input  logic cond,
  input  logic lvl_sel,
  input  logic sw_clr,
  input  logic ack_hit,
  output logic flag,
  output logic set_ev,
  output logic auto_clr,
  output logic lvl_act
);

  logic flag_nx;

  assign lvl_act  = (KIND == SRC_EXT) && lvl_sel;
  assign set_ev   = smp_tick & cond & ~lvl_act;
  assign auto_clr = ack_hit & ((KIND == SRC_TIMER) ||
                               ((KIND == SRC_EXT) && !lvl_sel));

  always_comb begin
    if (lvl_act) flag_nx = smp_tick ? cond : flag;
    else         flag_nx = latch_next(flag, set_ev, sw_clr | auto_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nx;
  end

endmodule

// File: rtl/irq_en_reg.sv
`timescale 1ns/1ps
module irq_en_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/irq_req_gate.sv
`timescale 1ns/1ps
module irq_req_gate
  import irq_gate_pkg::*;
#(
  parameter int N_SRC     = 7,
  parameter int PFAIL_IDX = 6
) (
  input  logic [N_SRC-1:0] flags,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie,
  output logic [N_SRC-1:0] req
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    localparam logic BYPASS = (i == PFAIL_IDX);
    assign req[i] = gate_req(flags[i], src_en[i], gie, BYPASS);
  end

endmodule

// File: rtl/irq_flag_gate.sv
`timescale 1ns/1ps
module irq_flag_gate
  import irq_gate_pkg::*;
#(
  parameter int N_SRC     = 7,
  parameter int ACK_W     = $clog2(N_SRC),
  parameter int EXT0_IDX  = 0,
  parameter int TMR0_IDX  = 1,
  parameter int EXT1_IDX  = 2,
  parameter int TMR1_IDX  = 3,
  parameter int PFAIL_IDX = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic [N_SRC-1:0] cond_in,
  input  logic [N_SRC-1:0] lvl_mode,
  input  logic             en_we,
  input  logic [N_SRC:0]   en_wdata,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic             ack_vld,
  input  logic [ACK_W-1:0] ack_idx,
  output logic [N_SRC-1:0] flags_o,
  output logic [N_SRC-1:0] req_o
);

  localparam int EN_W = N_SRC + 1;

  // named internal events, observed by the bound checker
  logic [EN_W-1:0]  en_q;
  logic [N_SRC-1:0] set_ev;
  logic [N_SRC-1:0] auto_clr;
  logic [N_SRC-1:0] sw_clr;
  logic [N_SRC-1:0] lvl_act;
  logic [N_SRC-1:0] ack_hit;

  assign sw_clr = clr_mask & {N_SRC{clr_we}};

  irq_en_reg #(.W(EN_W)) u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (en_we),
    .wdata (en_wdata),
    .q     (en_q)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam src_kind_e KIND =
      src_kind(i, EXT0_IDX, EXT1_IDX, TMR0_IDX, TMR1_IDX);

    assign ack_hit[i] = ack_vld && (ack_idx == ACK_W'(i));

    irq_flag_cell #(.KIND(KIND)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_tick (mc_tick),
      .cond     (cond_in[i]),
      .lvl_sel  (lvl_mode[i]),
      .sw_clr   (sw_clr[i]),
      .ack_hit  (ack_hit[i]),
      .flag     (flags_o[i]),
      .set_ev   (set_ev[i]),
      .auto_clr (auto_clr[i]),
      .lvl_act  (lvl_act[i])
    );
  end

  irq_req_gate #(.N_SRC(N_SRC), .PFAIL_IDX(PFAIL_IDX)) u_gate (
    .flags  (flags_o),
    .src_en (en_q[N_SRC-1:0]),
    .gie    (en_q[N_SRC]),
    .req    (req_o)
  );

endmodule

// File: rtl/irq_flag_gate_chk.sv
`timescale 1ns/1ps
module irq_flag_gate_chk #(
  parameter int N_SRC     = 7,
  parameter int PFAIL_IDX = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_tick,
  input logic [N_SRC-1:0] cond_in,
  input logic             ack_vld,
  input logic             en_we,
  input logic [N_SRC:0]   en_wdata,
  input logic [N_SRC-1:0] flags_o,
  input logic [N_SRC-1:0] req_o,
  input logic [N_SRC:0]   en_q,
  input logic [N_SRC-1:0] set_ev,
  input logic [N_SRC-1:0] auto_clr,
  input logic [N_SRC-1:0] sw_clr,
  input logic [N_SRC-1:0] lvl_act
);

  localparam logic [N_SRC-1:0] PF_MASK = N_SRC'(1) << PFAIL_IDX;

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |set_ev |=> ((flags_o & $past(set_ev)) == $past(set_ev)));

  // R2
  no_tick_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_tick |=> ((flags_o & ~$past(flags_o)) == '0));

  // R3
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(sw_clr & ~set_ev & ~lvl_act) |=>
      ((flags_o & $past(sw_clr & ~set_ev & ~lvl_act)) == '0));

  // R4
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_ev & (sw_clr | auto_clr)) |=>
      ((flags_o & $past(set_ev)) == $past(set_ev)));

  // R5
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(auto_clr & ~set_ev) |=> ((flags_o & $past(auto_clr & ~set_ev)) == '0));

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_tick |=> ((flags_o & $past(lvl_act)) == $past(cond_in & lvl_act)));

  // R8
  no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_vld |-> (auto_clr == '0));

  // R9
  req_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~(flags_o & en_q[N_SRC-1:0])) == '0);

  // R10
  gie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[N_SRC] |-> ((req_o & ~PF_MASK) == '0));

  // R11
  pf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o[PFAIL_IDX] == (flags_o[PFAIL_IDX] & en_q[PFAIL_IDX]));

  // R12
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en_q == $past(en_wdata)));

  // R13
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (flags_o == '0 && en_q == '0));

endmodule

bind irq_flag_gate irq_flag_gate_chk #(.N_SRC(N_SRC), .PFAIL_IDX(PFAIL_IDX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mc_tick  (mc_tick),
  .cond_in  (cond_in),
  .ack_vld  (ack_vld),
  .en_we    (en_we),
  .en_wdata (en_wdata),
  .flags_o  (flags_o),
  .req_o    (req_o),
  .en_q     (en_q),
  .set_ev   (set_ev),
  .auto_clr (auto_clr),
  .sw_clr   (sw_clr),
  .lvl_act  (lvl_act)
);

// File: tb/irq_flag_gate_test.sv
`timescale 1ns/1ps
module irq_flag_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0;
  logic [6:0] cond_in = '0;
  logic [6:0] lvl_mode = '0;
  logic       en_we = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       clr_we = 1'b0;
  logic [6:0] clr_mask = '0;
  logic       ack_vld = 1'b0;
  logic [2:0] ack_idx = '0;
  logic [6:0] flags_o;
  logic [6:0] req_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  irq_flag_gate uut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cond_in(cond_in),
    .lvl_mode(lvl_mode), .en_we(en_we), .en_wdata(en_wdata),
    .clr_we(clr_we), .clr_mask(clr_mask), .ack_vld(ack_vld),
    .ack_idx(ack_idx), .flags_o(flags_o), .req_o(req_o)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  logic [6:0] m_flag = '0;
  logic [7:0] m_en = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= '0;
      m_en   <= '0;
    end else begin
      logic [6:0] nf;
      nf = m_flag;
      for (int i = 0; i < 7; i++) begin
        bit is_ext;
        bit is_tmr;
        bit hit;
        is_ext = (i == 0 || i == 2);
        is_tmr = (i == 1 || i == 3);
        hit = ack_vld && (int'(ack_idx) == i);
        if (is_ext && lvl_mode[i]) begin
          if (mc_tick) nf[i] = cond_in[i];
        end else if (mc_tick && cond_in[i]) begin
          nf[i] = 1'b1;
        end else if ((clr_we && clr_mask[i]) || (hit && (is_tmr || is_ext))) begin
          nf[i] = 1'b0;
        end
      end
      m_flag <= nf;
      if (en_we) m_en <= en_wdata;
    end
  end

  function automatic logic [6:0] model_req();
    logic [6:0] r;
    for (int i = 0; i < 7; i++)
      r[i] = m_flag[i] && m_en[i] && (m_en[7] || i == 6);
    return r;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (flags_o !== m_flag) begin
        bad++;
        $display("FAIL R1 model flags: got %h expected %h", flags_o, m_flag);
      end
      total++;
      if (req_o !== model_req()) begin
        bad++;
        $display("FAIL R9 model req: got %h expected %h", req_o, model_req());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one cycle starting just after a falling edge, then return to idle
  task automatic cyc(input logic tk, input logic [6:0] cd,
                     input logic cw, input logic [6:0] cm,
                     input logic av, input logic [2:0] ai,
                     input logic ew, input logic [7:0] ed);
    mc_tick = tk; cond_in = cd; clr_we = cw; clr_mask = cm;
    ack_vld = av; ack_idx = ai; en_we = ew; en_wdata = ed;
    @(negedge clk);
    mc_tick = 1'b0; cond_in = '0; clr_we = 1'b0; clr_mask = '0;
    ack_vld = 1'b0; ack_idx = '0; en_we = 1'b0; en_wdata = '0;
  endtask

  task automatic set_tick(input logic [6:0] cd);
    cyc(1'b1, cd, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask
  task automatic sw_clear(input logic [6:0] m);
    cyc(1'b0, '0, 1'b1, m, 1'b0, '0, 1'b0, '0);
  endtask
  task automatic ack(input logic v, input logic [2:0] i);
    cyc(1'b0, '0, 1'b0, '0, v, i, 1'b0, '0);
  endtask
  task automatic wr_en(input logic [7:0] d);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk("R13 flags after reset", {1'b0, flags_o}, 8'h00);
    chk("R13 req after reset", {1'b0, req_o}, 8'h00);

    set_tick(7'h7F);
    chk("R1 flags set while disabled", {1'b0, flags_o}, 8'h7F);
    chk("R9 no req while disabled", {1'b0, req_o}, 8'h00);

    sw_clear(7'h7F);
    chk("R3 clear all", {1'b0, flags_o}, 8'h00);
    cyc(1'b0, 7'h7F, 1'b0, '0, 1'b0, '0, 1'b0, '0);
    chk("R2 no tick no set", {1'b0, flags_o}, 8'h00);

    set_tick(7'h7F);
    wr_en(8'h7F);
    chk("R10 global off blocks all but power-fail", {1'b0, req_o}, 8'h40);
    wr_en(8'hFF);
    chk("R12 enable write seen next cycle", {1'b0, req_o}, 8'h7F);
    wr_en(8'h85);
    chk("R9 only enabled sources request", {1'b0, req_o}, 8'h05);
    wr_en(8'h40);
    chk("R11 power-fail ignores global", {1'b0, req_o}, 8'h40);
    wr_en(8'h00);
    chk("R11 power-fail needs own enable", {1'b0, req_o}, 8'h00);

    sw_clear(7'h05);
    chk("R3 partial clear", {1'b0, flags_o}, 8'h7A);

    cyc(1'b1, 7'h01, 1'b1, 7'h01, 1'b0, '0, 1'b0, '0);
    chk("R4 set beats sw clear", {1'b0, flags_o}, 8'h7B);

    ack(1'b1, 3'd0);
    chk("R5 ext0 edge ack clears", {1'b0, flags_o}, 8'h7A);
    set_tick(7'h04);
    ack(1'b1, 3'd2);
    chk("R5 ext1 edge ack clears", {1'b0, flags_o}, 8'h7A);
    cyc(1'b1, 7'h04, 1'b0, '0, 1'b1, 3'd2, 1'b0, '0);
    chk("R4 set beats ack clear", {1'b0, flags_o}, 8'h7E);
    sw_clear(7'h04);

    ack(1'b1, 3'd1);
    chk("R7 timer0 ack clears", {1'b0, flags_o}, 8'h78);
    ack(1'b1, 3'd3);
    chk("R7 timer1 ack clears", {1'b0, flags_o}, 8'h70);
    ack(1'b1, 3'd4);
    chk("R7 plain source ack ignored", {1'b0, flags_o}, 8'h70);
    ack(1'b1, 3'd6);
    chk("R7 power-fail ack ignored", {1'b0, flags_o}, 8'h70);

    ack(1'b0, 3'd5);
    chk("R8 index ignored without ack", {1'b0, flags_o}, 8'h70);

    lvl_mode = 7'h01;
    set_tick(7'h01);
    chk("R6 level flag loads condition", {1'b0, flags_o}, 8'h71);
    ack(1'b1, 3'd0);
    chk("R6 level flag ignores ack", {1'b0, flags_o}, 8'h71);
    sw_clear(7'h01);
    chk("R6 level flag ignores sw clear", {1'b0, flags_o}, 8'h71);
    set_tick(7'h00);
    chk("R6 level flag follows low condition", {1'b0, flags_o}, 8'h70);
    lvl_mode = 7'h11;
    set_tick(7'h00);
    chk("R6 mode ignored on plain source", {1'b0, flags_o}, 8'h70);
    lvl_mode = '0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R13 flags after mid-run reset", {1'b0, flags_o}, 8'h00);

    // random traffic, checked against the model every clock
    for (int n = 0; n < 500; n++) begin
      lvl_mode = 7'($urandom);
      cyc(1'($urandom), 7'($urandom), ($urandom % 4) == 0, 7'($urandom),
          ($urandom % 3) == 0, 3'($urandom), ($urandom % 8) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule